// File: doc/BRIEF.md
# Most-Significant-Digit-First Minimum Keeper with Early Stop

This block keeps the smallest sum of absolute differences seen so far in a motion search and judges each new candidate against it while the candidate is still arriving. Both the kept minimum and the candidate are radix-2 signed-digit numbers. Each digit is a (plus, minus) bit pair and the digits arrive one per cycle, most significant first. At every digit the block updates the signed difference between the candidate prefix and the kept prefix. In that same cycle it raises a stop signal once the candidate can no longer end up smaller. Upstream can then drop the rest of that candidate and move to the next search position.

A candidate that reaches its last digit without a stop, and whose value is strictly below the kept minimum, is written in as the new minimum. The search-position tag given with its first digit is written in with it. Candidate digits are held in a side buffer while they stream, so the kept minimum is only ever replaced by a finished, winning candidate.

Top module: `sdmin_early_cmp`

## Requirements
- R1: While reset is held, and in the first cycle after it, every kept digit is +1: `min_p` is all ones, `min_n` is all zeros and `min_tag` is zero. `stop` and `commit` are low.
- R2: A digit pair (p, n) has the value p − n, so (1,0) is +1, (0,1) is −1, and both (0,0) and (1,1) are 0. A candidate has exactly NDIG digits. `cand_start` marks the first digit and `dig_last` marks digit NDIG−1. Digit i, counted from 0 at the first digit, weighs 2^(NDIG−1−i). In the kept vectors, digit i sits at bit NDIG−1−i.
- R3: `stop` depends combinationally on the current digit. It is high in the earliest digit cycle at which the candidate is certainly larger than the minimum. That is the first digit where (candidate prefix − minimum prefix) · 2^r > 2·(2^r − 1), with r the number of digits still to come. At the last digit this means the total difference is positive.
- R4: Once `stop` has been raised, the remaining digits of that candidate are ignored. `stop` stays low for them, no commit follows and the kept minimum is unchanged.
- R5: When a candidate that was never stopped ends with a value strictly below the minimum, `commit` is high for exactly one cycle, in the cycle after its last digit. From that cycle on, `min_p`/`min_n` hold the candidate's own digit pairs and `min_tag` holds the `pos_tag` that was sampled with `cand_start`.
- R6: A candidate whose value equals the minimum causes neither `stop` nor `commit`, and the minimum is unchanged.
- R7: The kept minimum and its tag change only in a cycle in which `commit` is high.
- R8: `stop` is low in any cycle in which `dig_vld` is low.
- R9: A `cand_start` that arrives while a candidate is still streaming abandons the old candidate. The new candidate is judged from its own first digit, as if it were the only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dig_vld | input | 1 | A candidate digit is present this cycle |
| cand_start | input | 1 | First digit of a new candidate |
| dig_last | input | 1 | Last digit of the candidate |
| dig_p | input | 1 | Plus bit of the candidate digit |
| dig_n | input | 1 | Minus bit of the candidate digit |
| pos_tag | input | TAG_W | Search-position tag, sampled with `cand_start` |
| stop | output | 1 | Candidate is known to be larger (same cycle) |
| commit | output | 1 | One-cycle pulse: a new minimum was written |
| min_p | output | NDIG | Plus bits of the kept minimum |
| min_n | output | NDIG | Minus bits of the kept minimum |
| min_tag | output | TAG_W | Tag of the kept minimum |

## Verification
The bench uses three digits. For every one of the 64 signed-digit encodings it first installs a minimum after reset. It then plays each of the 64 encodings against that minimum. This covers redundant forms of equal values, ties, stops at the first, middle and last digit, and candidates that win only on their last digit. Because the tail digits keep streaming after a stop, a wrong stop cycle is caught, and so is a block that fails to ignore those digits. Short directed runs restart a candidate part-way through, to show that nothing is carried over from the abandoned prefix.

// File: rtl/sdmin_pkg.sv
// Shared types for the signed-digit minimum keeper.
// Assumes the running difference is clamped to [-2, 1] between digits.
package sdmin_pkg;
    typedef logic signed [2:0] sdmin_run_t;   // clamped running difference
    typedef logic signed [4:0] sdmin_acc_t;   // one-digit update result
endpackage

// File: rtl/sdmin_diff_track.sv
// Running-difference tracker: it follows (candidate - minimum) one digit at a
// time, decides "certainly larger" in the same cycle and flags a smaller
// candidate at its last digit. It assumes NDIG digits per candidate, MSB first.
module sdmin_diff_track
    import sdmin_pkg::*;
#(
    parameter int NDIG  = 13,
    parameter int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dig_vld,
    input  logic             cand_start,
    input  logic             dig_last,
    input  logic             dig_p,
    input  logic             dig_n,
    input  logic             ref_p,
    input  logic             ref_n,
    output logic [IDX_W-1:0] cur_idx,
    output logic             live,
    output logic             stop,
    output logic             end_smaller,
    output logic             commit
);
    logic             active_q;
    sdmin_run_t       d_q;
    sdmin_run_t       d_base;
    sdmin_run_t       d_nxt;
    sdmin_acc_t       d_raw;
    logic [IDX_W-1:0] idx_q;
    logic             greater;
    logic             commit_q;

    // Purpose: digit update and same-cycle larger/smaller decision.
    always_comb begin
        live     = dig_vld && (cand_start || active_q);
        cur_idx  = cand_start ? IDX_W'(NDIG - 1) : idx_q;
        d_base   = cand_start ? '0 : d_q;
        d_raw    = 5'(d_base) + 5'(d_base) + 5'(dig_p) + 5'(ref_n)
                 - 5'(dig_n) - 5'(ref_p);
        greater  = (d_raw >= 5'sd2) || (dig_last && (d_raw >= 5'sd1));
        stop     = live && greater;
        end_smaller = live && dig_last && (d_raw < 5'sd0);
        d_nxt    = (d_raw < -5'sd2) ? -3'sd2 : d_raw[2:0];
    end

    // Purpose: hold the candidate state between digits and register commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            d_q      <= '0;
            idx_q    <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= end_smaller;
            if (live) begin
                active_q <= !(greater || dig_last);
                d_q      <= d_nxt;
                idx_q    <= cur_idx - 1'b1;
            end
        end
    end

    assign commit = commit_q;

    AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (d_q >= -3'sd2) && (d_q <= 3'sd1)); // R3
    AST_LAST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (live && dig_last) |-> (cur_idx == '0)); // R2
    AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(dig_vld && dig_last)); // R5
endmodule

// File: rtl/sdmin_cand_buf.sv
// Candidate buffer: shifts in the digits of the streaming candidate and keeps
// the tag given with its first digit. It assumes NDIG >= 2.
module sdmin_cand_buf #(
    parameter int NDIG  = 13,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             dig_vld,
    input  logic             cand_start,
    input  logic             dig_p,
    input  logic             dig_n,
    input  logic [TAG_W-1:0] pos_tag,
    output logic [NDIG-1:0]  full_p,
    output logic [NDIG-1:0]  full_n,
    output logic [TAG_W-1:0] cand_tag
);
    logic [NDIG-2:0]  sh_p;
    logic [NDIG-2:0]  sh_n;
    logic [TAG_W-1:0] tag_q;

    // Purpose: the whole candidate word as it stands after this digit.
    always_comb begin
        full_p   = {sh_p, dig_p};
        full_n   = {sh_n, dig_n};
        cand_tag = tag_q;
    end

    // Purpose: shift accepted digits in and capture the tag on a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_p  <= '0;
            sh_n  <= '0;
            tag_q <= '0;
        end else begin
            if (live) begin
                sh_p <= cand_start ? {{(NDIG-2){1'b0}}, dig_p} : full_p[NDIG-2:0];
                sh_n <= cand_start ? {{(NDIG-2){1'b0}}, dig_n} : full_n[NDIG-2:0];
            end
            if (cand_start && dig_vld)
                tag_q <= pos_tag;
        end
    end
endmodule

// File: rtl/sdmin_min_store.sv
// Minimum store: the kept signed-digit minimum and its tag. Reset loads the
// largest value (all digits +1); a load copies in a finished candidate.
module sdmin_min_store #(
    parameter int NDIG  = 13,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NDIG-1:0]  new_p,
    input  logic [NDIG-1:0]  new_n,
    input  logic [TAG_W-1:0] new_tag,
    output logic [NDIG-1:0]  min_p,
    output logic [NDIG-1:0]  min_n,
    output logic [TAG_W-1:0] min_tag
);
    // Purpose: reset to the maximum, or replace on a winning candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_p   <= '1;
            min_n   <= '0;
            min_tag <= '0;
        end else if (load) begin
            min_p   <= new_p;
            min_n   <= new_n;
            min_tag <= new_tag;
        end
    end
endmodule

// File: rtl/sdmin_early_cmp.sv
// Top: it compares a signed-digit SAD stream against the kept minimum, stops
// early on a larger candidate and commits a smaller one after its last digit.
// It assumes NDIG digits per candidate, most significant first, with NDIG >= 2.
module sdmin_early_cmp #(
    parameter int NDIG  = 13,
    parameter int TAG_W = 8,
    parameter int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dig_vld,
    input  logic             cand_start,
    input  logic             dig_last,
    input  logic             dig_p,
    input  logic             dig_n,
    input  logic [TAG_W-1:0] pos_tag,
    output logic             stop,
    output logic             commit,
    output logic [NDIG-1:0]  min_p,
    output logic [NDIG-1:0]  min_n,
    output logic [TAG_W-1:0] min_tag
);
    logic [IDX_W-1:0] cur_idx;
    logic             live;
    logic             end_smaller;
    logic             ref_p;
    logic             ref_n;
    logic [NDIG-1:0]  full_p;
    logic [NDIG-1:0]  full_n;
    logic [TAG_W-1:0] cand_tag;

    // Purpose: pick the kept digit that lines up with the incoming one.
    always_comb begin
        ref_p = min_p[cur_idx];
        ref_n = min_n[cur_idx];
    end

    sdmin_diff_track #(.NDIG(NDIG), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .dig_vld(dig_vld), .cand_start(cand_start),
        .dig_last(dig_last), .dig_p(dig_p), .dig_n(dig_n),
        .ref_p(ref_p), .ref_n(ref_n), .cur_idx(cur_idx), .live(live),
        .stop(stop), .end_smaller(end_smaller), .commit(commit)
    );

    sdmin_cand_buf #(.NDIG(NDIG), .TAG_W(TAG_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .live(live), .dig_vld(dig_vld),
        .cand_start(cand_start), .dig_p(dig_p), .dig_n(dig_n),
        .pos_tag(pos_tag), .full_p(full_p), .full_n(full_n), .cand_tag(cand_tag)
    );

    sdmin_min_store #(.NDIG(NDIG), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(end_smaller),
        .new_p(full_p), .new_n(full_n), .new_tag(cand_tag),
        .min_p(min_p), .min_n(min_n), .min_tag(min_tag)
    );

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> $stable({min_p, min_n, min_tag})); // R7
    AST_STOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_vld |-> !stop); // R8
endmodule

// File: tb/sim_sdmin_early_cmp.sv
// Bench: every 3-digit minimum against every 3-digit candidate, plus restarts.
module sim_sdmin_early_cmp;
    localparam int N  = 3;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dig_vld = 1'b0, cand_start = 1'b0, dig_last = 1'b0;
    logic dig_p = 1'b0, dig_n = 1'b0;
    logic [TW-1:0] pos_tag = '0;
    logic stop, commit;
    logic [N-1:0] min_p, min_n;
    logic [TW-1:0] min_tag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [N-1:0] e_mp, e_mn;
    logic [TW-1:0] e_tag;

    always #5 clk = ~clk;

    sdmin_early_cmp #(.NDIG(N), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .dig_vld(dig_vld), .cand_start(cand_start),
        .dig_last(dig_last), .dig_p(dig_p), .dig_n(dig_n), .pos_tag(pos_tag),
        .stop(stop), .commit(commit), .min_p(min_p), .min_n(min_n),
        .min_tag(min_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Value of digits 0..k of a signed-digit word (digit i at bit N-1-i).
    function automatic int pref(input logic [N-1:0] p, input logic [N-1:0] n, input int k);
        int v = 0;
        for (int i = 0; i <= k; i++) v = 2 * v + int'(p[N-1-i]) - int'(n[N-1-i]);
        return v;
    endfunction

    task automatic to_vec(input int rep, output logic [N-1:0] p, output logic [N-1:0] n);
        for (int i = 0; i < N; i++) begin
            int code = (rep >> (2 * (N - 1 - i))) & 3;
            p[N-1-i] = code[1];
            n[N-1-i] = code[0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dig_vld = 0; cand_start = 0; dig_last = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e_mp = '1; e_mn = '0; e_tag = '0;
        #1;
        chk(min_p == '1 && min_n == '0 && min_tag == '0, "R1 min", int'({min_p, min_n}), int'({e_mp, e_mn}));
        chk(!stop && !commit, "R1 ctl", int'({stop, commit}), 0);
    endtask

    // Stream one full candidate and check stop per digit, then commit and minimum.
    task automatic run_cand(input int rep, input logic [TW-1:0] tg);
        logic [N-1:0] cp, cn;
        bit stopped = 0;
        bit exp_c;
        int cv, mv;
        to_vec(rep, cp, cn);
        cv = pref(cp, cn, N - 1);
        mv = pref(e_mp, e_mn, N - 1);
        for (int i = 0; i < N; i++) begin
            int pd, r;
            bit es;
            @(negedge clk);
            dig_vld = 1; cand_start = (i == 0); dig_last = (i == N - 1);
            dig_p = cp[N-1-i]; dig_n = cn[N-1-i]; pos_tag = tg;
            #1;
            pd = pref(cp, cn, i) - pref(e_mp, e_mn, i);
            r = N - 1 - i;
            es = !stopped && (pd * (1 << r) > 2 * ((1 << r) - 1));
            chk(stop == es, stopped ? "R4 stop after stop" : "R3 stop", int'(stop), int'(es));
            if (es) stopped = 1;
        end
        @(negedge clk);
        dig_vld = 0; cand_start = 0; dig_last = 0;
        #1;
        chk(!stop, "R8 idle stop", int'(stop), 0);
        exp_c = !stopped && (cv < mv);
        chk(commit == exp_c, stopped ? "R4 commit" : (cv == mv ? "R6 commit" : "R5 commit"),
            int'(commit), int'(exp_c));
        if (exp_c) begin e_mp = cp; e_mn = cn; e_tag = tg; end
        chk(min_p == e_mp && min_n == e_mn, exp_c ? "R5 min" : "R7 min",
            int'({min_p, min_n}), int'({e_mp, e_mn}));
        chk(min_tag == e_tag, exp_c ? "R5 tag" : "R7 tag", int'(min_tag), int'(e_tag));
        @(negedge clk);
        #1;
        chk(!commit, "R5 one-cycle", int'(commit), 0);
    endtask

    // One orphan first digit (value -1) that must be abandoned by the next start.
    task automatic orphan_digit();
        @(negedge clk);
        dig_vld = 1; cand_start = 1; dig_last = 0; dig_p = 0; dig_n = 1; pos_tag = 8'hEE;
    endtask

    initial begin
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                do_reset();
                run_cand(a, TW'(a));
                run_cand(b, TW'(8'h80 | b));
            end
        end
        // R9: restarts part-way through a candidate
        for (int b = 0; b < 64; b += 7) begin
            do_reset();
            orphan_digit();
            run_cand(b, TW'(8'h40 | b));
            orphan_digit();
            run_cand(63 - b, TW'(8'h20 | b));
            chk(min_tag == e_tag, "R9 restart", int'(min_tag), int'(e_tag));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule